// File: doc/BRIEF.md
# Write-Update Snooping Cache Controller

This block is the coherence controller of one processor's private cache on a shared snooping bus. It keeps a direct-mapped array of one-word lines and holds every line in one of five conditions: invalid, exclusive-clean, exclusive-modified, shared-clean or shared-modified. Copies in other caches are never invalidated. When the processor stores to a line that others may hold, the controller broadcasts the new word so that every peer holding the line overwrites its copy in place. A wired-OR shared line, raised by every snooping cache that holds the addressed line, tells the writer whether sharing still continues. When sharing ends, the writer takes the line exclusive and stops broadcasting.

The processor side is a simple request/done pair: it holds the request stable until `cpuDone` rises. The bus side requests the bus, waits for a grant from an external arbiter, and completes one command in the grant cycle. In that cycle the peers answer with the shared wire and, on a read, with line data supplied from cache to cache. If no peer supplies the data, the controller waits for memory. On the same bus, the snoop port watches commands from other masters and answers them in the cycle they appear. A shared-modified line lets caches hold a dirty word jointly: update broadcasts refresh the peers but leave memory untouched, and the owner writes the line back when it evicts it.

Top module: `wupd_cache`

## Requirements
- R1: After reset every line is invalid: `busReq`, `cpuDone`, `shOut` and `supplyValidOut` are low, and snoops to any address get no response.
- R2: A processor store that hits a shared line (clean or modified) requests the bus. In the grant cycle it drives command 2 (update) with the store address and the new word, and completes the store in that same cycle. Bus command codes are 0 idle, 1 read, 2 update and 3 write-back.
- R3: A snooped update (command 2) to a held line raises `shOut` in that cycle, overwrites the local word with the snooped data and leaves the line shared-clean.
- R4: After an update cycle in which `shIn` was high, the line is shared-modified and the next store broadcasts again. If `shIn` was low, the line is exclusive-modified and later stores to it make no bus request.
- R5: A shared-modified line is never written to memory by update cycles. It is written back, with command 3, only when it is evicted.
- R6: A miss whose victim line (same index, the low SET_BITS address bits) is modified first issues a write-back carrying the victim's address and data, then a read. A clean or invalid victim is dropped silently, so the read is the first bus command.
- R7: On a read grant with `supplyValidIn` high, the line is filled from `supplyDataIn` and the request completes without waiting for `memAck`. Otherwise the fill comes from `memData` when `memAck` pulses.
- R8: A load miss fills the line shared-clean if `shIn` was high in the read grant cycle, and exclusive-clean otherwise.
- R9: A store hit on an exclusive-clean or exclusive-modified line completes with no bus request and leaves the line exclusive-modified.
- R10: A snooped read (command 1) to a held line raises `shOut` and `supplyValidOut` in that cycle, with the line's word on `supplyDataOut`. The line is downgraded from exclusive-clean to shared-clean, or from exclusive-modified to shared-modified.
- R11: Snooped write-backs, idle cycles and snoops to addresses that are not held raise neither `shOut` nor `supplyValidOut` and change no line.
- R12: A store miss first fills the line like a load miss. It then completes as a store hit on the filled line, broadcasting an update if the fill was shared.
- R13: A load hit completes in the cycle it is seen and returns the line's word on `cpuRdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpuReq | input | 1 | Processor request, held until done |
| cpuWe | input | 1 | 1 store, 0 load |
| cpuAddr | input | ADDR_W | Word address |
| cpuWdata | input | DATA_W | Store data |
| cpuRdata | output | DATA_W | Load data, valid with cpuDone |
| cpuDone | output | 1 | Request completes this cycle |
| busReq | output | 1 | Bus request to arbiter |
| busGnt | input | 1 | Bus grant, one command per grant cycle |
| busCmdOut | output | 2 | Command driven while granted |
| busAddrOut | output | ADDR_W | Address of the command |
| busDataOut | output | DATA_W | Update or write-back data |
| shIn | input | 1 | Wired-OR shared status from peers |
| supplyValidIn | input | 1 | A peer supplies the read data |
| supplyDataIn | input | DATA_W | Peer-supplied word |
| memAck | input | 1 | Memory read data valid |
| memData | input | DATA_W | Memory read data |
| snpCmd | input | 2 | Command of another bus master |
| snpAddr | input | ADDR_W | Snooped address |
| snpData | input | DATA_W | Snooped update data |
| shOut | output | 1 | This cache holds the snooped line |
| supplyValidOut | output | 1 | This cache supplies snooped read data |
| supplyDataOut | output | DATA_W | Word of the line at the snooped index |

## Verification
The bench builds the controller with an 8-bit address, 16-bit words and two index bits, so only four sets exist. Addresses four words apart collide, which makes write-backs of exclusive-modified and shared-modified victims, and silent drops of clean ones, easy to reach with a handful of accesses. With the small tag field, a behavioural model of states, tags, words and memory stays short, and the bench can predict every bus command, shared response and supplied word that each access and snoop should produce.

// File: rtl/wupd_pkg.sv
package wupd_pkg;

  typedef enum logic [2:0] {
    LS_INV = 3'd0,
    LS_EC  = 3'd1,
    LS_EM  = 3'd2,
    LS_SC  = 3'd3,
    LS_SM  = 3'd4
  } lineState_e;

  typedef enum logic [1:0] {
    BC_IDLE = 2'd0,
    BC_READ = 2'd1,
    BC_UPD  = 2'd2,
    BC_WB   = 2'd3
  } busCmd_e;

  typedef enum logic [1:0] {
    SRC_CPU  = 2'd0,
    SRC_PEER = 2'd1,
    SRC_MEM  = 2'd2
  } lineSrc_e;

  // strobes from control to datapath, all aimed at the set picked by cpuAddr
  typedef struct packed {
    logic       lineWr;
    logic       setTag;
    lineSrc_e   src;
    lineState_e newState;
  } ctrlStb_t;

  function automatic logic isDirty(lineState_e s);
    return (s == LS_EM) || (s == LS_SM);
  endfunction

  function automatic logic isShared(lineState_e s);
    return (s == LS_SC) || (s == LS_SM);
  endfunction

endpackage

// File: rtl/wupd_dpath.sv
module wupd_dpath
  import wupd_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 16,
  parameter int SET_BITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  ctrlStb_t          stb,
  input  busCmd_e           busCmd,
  input  logic [DATA_W-1:0] supplyDataIn,
  input  logic [DATA_W-1:0] memData,
  input  busCmd_e           snpCmd,
  input  logic [ADDR_W-1:0] snpAddr,
  input  logic [DATA_W-1:0] snpData,
  output lineState_e        hitState,
  output lineState_e        victimState,
  output logic [DATA_W-1:0] cpuRdata,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busData,
  output logic              shOut,
  output logic              supplyValid,
  output logic [DATA_W-1:0] supplyData
);

  localparam int NUM_SETS = 1 << SET_BITS;
  localparam int TAG_W    = ADDR_W - SET_BITS;

  lineState_e              stArr  [NUM_SETS];
  logic [TAG_W-1:0]        tagArr [NUM_SETS];
  logic [DATA_W-1:0]       datArr [NUM_SETS];

  logic [SET_BITS-1:0] cpuIdx, snpIdx;
  logic [TAG_W-1:0]    cpuTag, snpTag;
  logic                snpHit;
  logic [DATA_W-1:0]   fillData;

  assign cpuIdx = cpuAddr[SET_BITS-1:0];
  assign cpuTag = cpuAddr[ADDR_W-1:SET_BITS];
  assign snpIdx = snpAddr[SET_BITS-1:0];
  assign snpTag = snpAddr[ADDR_W-1:SET_BITS];

  assign snpHit = (stArr[snpIdx] != LS_INV) && (tagArr[snpIdx] == snpTag);

  always_comb begin
    unique case (stb.src)
      SRC_PEER: fillData = supplyDataIn;
      SRC_MEM:  fillData = memData;
      default:  fillData = cpuWdata;
    endcase
  end

  // one storage slice per set
  for (genvar g = 0; g < NUM_SETS; g++) begin : gSet
    lineState_e        st;
    logic [TAG_W-1:0]  tg;
    logic [DATA_W-1:0] dat;
    logic              ctrlSel, snpSel;

    assign ctrlSel = stb.lineWr && (cpuIdx == SET_BITS'(g));
    assign snpSel  = snpHit && (snpIdx == SET_BITS'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st  <= LS_INV;
        tg  <= '0;
        dat <= '0;
      end else if (ctrlSel) begin
        st <= stb.newState;
        if (stb.setTag) tg <= cpuTag;
        if (stb.newState != LS_INV) dat <= fillData;
      end else if (snpSel) begin
        unique case (snpCmd)
          BC_READ: begin
            if (st == LS_EC) st <= LS_SC;
            else if (st == LS_EM) st <= LS_SM;
          end
          BC_UPD: begin
            dat <= snpData;
            st  <= LS_SC;
          end
          default: ;
        endcase
      end
    end

    assign stArr[g]  = st;
    assign tagArr[g] = tg;
    assign datArr[g] = dat;
  end

  assign victimState = stArr[cpuIdx];
  assign hitState    = (tagArr[cpuIdx] == cpuTag) ? stArr[cpuIdx] : LS_INV;
  assign cpuRdata    = datArr[cpuIdx];

  always_comb begin
    busAddr = cpuAddr;
    busData = '0;
    unique case (busCmd)
      BC_WB: begin
        busAddr = {tagArr[cpuIdx], cpuIdx};
        busData = datArr[cpuIdx];
      end
      BC_UPD:  busData = cpuWdata;
      default: ;
    endcase
  end

  assign shOut       = snpHit && ((snpCmd == BC_READ) || (snpCmd == BC_UPD));
  assign supplyValid = snpHit && (snpCmd == BC_READ);
  assign supplyData  = datArr[snpIdx];

endmodule

// File: rtl/wupd_ctrl.sv
module wupd_ctrl
  import wupd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpuReq,
  input  logic       cpuWe,
  input  logic       snpBusy,
  input  lineState_e hitState,
  input  lineState_e victimState,
  input  logic       busGnt,
  input  logic       shIn,
  input  logic       supplyValidIn,
  input  logic       memAck,
  output logic       busReq,
  output busCmd_e    busCmd,
  output logic       cpuDone,
  output ctrlStb_t   stb
);

  typedef enum logic [2:0] {
    C_IDLE, C_UPD, C_WB, C_RD, C_MEMW
  } ctrlState_e;

  ctrlState_e curState, nxtState;
  logic       shSeen, shSeenNxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      curState <= C_IDLE;
      shSeen   <= 1'b0;
    end else begin
      curState <= nxtState;
      shSeen   <= shSeenNxt;
    end
  end

  always_comb begin
    nxtState  = curState;
    shSeenNxt = shSeen;
    busReq    = 1'b0;
    busCmd    = BC_IDLE;
    cpuDone   = 1'b0;
    stb       = '0;
    unique case (curState)
      C_IDLE: begin
        if (cpuReq && !snpBusy) begin
          if (hitState != LS_INV) begin
            if (!cpuWe) begin
              cpuDone = 1'b1;
            end else if (isShared(hitState)) begin
              nxtState = C_UPD;
            end else begin
              cpuDone      = 1'b1;
              stb.lineWr   = 1'b1;
              stb.src      = SRC_CPU;
              stb.newState = LS_EM;
            end
          end else begin
            nxtState = isDirty(victimState) ? C_WB : C_RD;
          end
        end
      end
      C_UPD: begin
        busReq = 1'b1;
        if (busGnt) begin
          busCmd       = BC_UPD;
          cpuDone      = 1'b1;
          stb.lineWr   = 1'b1;
          stb.src      = SRC_CPU;
          stb.newState = shIn ? LS_SM : LS_EM;
          nxtState     = C_IDLE;
        end
      end
      C_WB: begin
        busReq = 1'b1;
        if (busGnt) begin
          busCmd       = BC_WB;
          stb.lineWr   = 1'b1;
          stb.newState = LS_INV;
          nxtState     = C_RD;
        end
      end
      C_RD: begin
        busReq = 1'b1;
        if (busGnt) begin
          busCmd = BC_READ;
          if (supplyValidIn) begin
            stb.lineWr   = 1'b1;
            stb.setTag   = 1'b1;
            stb.src      = SRC_PEER;
            stb.newState = shIn ? LS_SC : LS_EC;
            nxtState     = C_IDLE;
          end else begin
            shSeenNxt = shIn;
            nxtState  = C_MEMW;
          end
        end
      end
      C_MEMW: begin
        if (memAck) begin
          stb.lineWr   = 1'b1;
          stb.setTag   = 1'b1;
          stb.src      = SRC_MEM;
          stb.newState = shSeen ? LS_SC : LS_EC;
          nxtState     = C_IDLE;
        end
      end
      default: nxtState = C_IDLE;
    endcase
  end

endmodule

// File: rtl/wupd_cache.sv
module wupd_cache
  import wupd_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 16,
  parameter int SET_BITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              cpuDone,
  output logic              busReq,
  input  logic              busGnt,
  output logic [1:0]        busCmdOut,
  output logic [ADDR_W-1:0] busAddrOut,
  output logic [DATA_W-1:0] busDataOut,
  input  logic              shIn,
  input  logic              supplyValidIn,
  input  logic [DATA_W-1:0] supplyDataIn,
  input  logic              memAck,
  input  logic [DATA_W-1:0] memData,
  input  logic [1:0]        snpCmd,
  input  logic [ADDR_W-1:0] snpAddr,
  input  logic [DATA_W-1:0] snpData,
  output logic              shOut,
  output logic              supplyValidOut,
  output logic [DATA_W-1:0] supplyDataOut
);

  ctrlStb_t   stb;
  busCmd_e    busCmd;
  lineState_e hitState, victimState;
  logic       snpBusy;

  assign snpBusy   = (snpCmd != 2'd0);
  assign busCmdOut = busCmd;

  wupd_ctrl ctrl_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpuReq       (cpuReq),
    .cpuWe        (cpuWe),
    .snpBusy      (snpBusy),
    .hitState     (hitState),
    .victimState  (victimState),
    .busGnt       (busGnt),
    .shIn         (shIn),
    .supplyValidIn(supplyValidIn),
    .memAck       (memAck),
    .busReq       (busReq),
    .busCmd       (busCmd),
    .cpuDone      (cpuDone),
    .stb          (stb)
  );

  wupd_dpath #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .SET_BITS(SET_BITS)
  ) dpath_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpuAddr     (cpuAddr),
    .cpuWdata    (cpuWdata),
    .stb         (stb),
    .busCmd      (busCmd),
    .supplyDataIn(supplyDataIn),
    .memData     (memData),
    .snpCmd      (busCmd_e'(snpCmd)),
    .snpAddr     (snpAddr),
    .snpData     (snpData),
    .hitState    (hitState),
    .victimState (victimState),
    .cpuRdata    (cpuRdata),
    .busAddr     (busAddrOut),
    .busData     (busDataOut),
    .shOut       (shOut),
    .supplyValid (supplyValidOut),
    .supplyData  (supplyDataOut)
  );

endmodule

// File: rtl/wupd_cache_chk.sv
module wupd_cache_chk #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 16,
  parameter int SET_BITS = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpuWe,
  input logic [ADDR_W-1:0] cpuAddr,
  input logic [DATA_W-1:0] cpuWdata,
  input logic              busReq,
  input logic              busGnt,
  input logic [1:0]        busCmdOut,
  input logic [ADDR_W-1:0] busAddrOut,
  input logic [DATA_W-1:0] busDataOut,
  input logic [1:0]        snpCmd,
  input logic [ADDR_W-1:0] snpAddr,
  input logic [DATA_W-1:0] snpData,
  input logic              shOut,
  input logic              supplyValidOut,
  input logic [DATA_W-1:0] supplyDataOut
);

  // R1
  bus_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busCmdOut != 2'd0) |-> (busGnt && busReq));

  // R2
  upd_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busCmdOut == 2'd2) |-> (cpuWe && busAddrOut == cpuAddr && busDataOut == cpuWdata));

  // R6
  wb_victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busCmdOut == 2'd3) |->
      (busAddrOut[SET_BITS-1:0] == cpuAddr[SET_BITS-1:0] && busAddrOut != cpuAddr));

  // R10
  supply_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    supplyValidOut |-> (shOut && snpCmd == 2'd1));

  // R11
  snoop_wb_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snpCmd == 2'd3 || snpCmd == 2'd0) |-> (!shOut && !supplyValidOut));

  // R3
  snoop_upd_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snpCmd == 2'd2 && shOut) |=>
      (snpAddr != $past(snpAddr) || supplyDataOut == $past(snpData)));

endmodule

bind wupd_cache wupd_cache_chk #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .SET_BITS(SET_BITS)
) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .cpuWe         (cpuWe),
  .cpuAddr       (cpuAddr),
  .cpuWdata      (cpuWdata),
  .busReq        (busReq),
  .busGnt        (busGnt),
  .busCmdOut     (busCmdOut),
  .busAddrOut    (busAddrOut),
  .busDataOut    (busDataOut),
  .snpCmd        (snpCmd),
  .snpAddr       (snpAddr),
  .snpData       (snpData),
  .shOut         (shOut),
  .supplyValidOut(supplyValidOut),
  .supplyDataOut (supplyDataOut)
);

// File: tb/wupd_cache_tb_top.sv
`timescale 1ns/100ps
module wupd_cache_tb_top;

  localparam int AW = 8;
  localparam int DW = 16;
  localparam int SB = 2;
  localparam int NS = 1 << SB;

  logic clk = 1'b0;
  logic rst_n;
  always #2.5 clk = ~clk;

  logic          cpuReq, cpuWe, cpuDone, busReq, busGnt, shIn;
  logic [AW-1:0] cpuAddr, busAddrOut, snpAddr;
  logic [DW-1:0] cpuWdata, cpuRdata, busDataOut, supplyDataIn, memData, snpData, supplyDataOut;
  logic [1:0]    busCmdOut, snpCmd;
  logic          supplyValidIn, memAck, shOut, supplyValidOut;

  wupd_cache #(.ADDR_W(AW), .DATA_W(DW), .SET_BITS(SB)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .cpuRdata(cpuRdata), .cpuDone(cpuDone),
    .busReq(busReq), .busGnt(busGnt), .busCmdOut(busCmdOut),
    .busAddrOut(busAddrOut), .busDataOut(busDataOut),
    .shIn(shIn), .supplyValidIn(supplyValidIn), .supplyDataIn(supplyDataIn),
    .memAck(memAck), .memData(memData),
    .snpCmd(snpCmd), .snpAddr(snpAddr), .snpData(snpData),
    .shOut(shOut), .supplyValidOut(supplyValidOut), .supplyDataOut(supplyDataOut)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // behavioural reference: 0 inv, 1 excl-clean, 2 excl-mod, 3 shared-clean, 4 shared-mod
  int          mSt  [NS];
  logic [AW-SB-1:0] mTag [NS];
  logic [DW-1:0] mData [NS];
  logic [DW-1:0] memOv [int];

  typedef struct {
    logic [1:0]    cmd;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    bit            chkData;
  } busExp_t;
  busExp_t expQ[$];

  function automatic logic [DW-1:0] memRd(int a);
    if (memOv.exists(a)) return memOv[a];
    return DW'(a * 37 + 5);
  endfunction

  task automatic chkEq(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // per-clock comparison of quiet outputs
  always @(negedge clk) begin
    #0.5;
    if (rst_n) begin
      if (snpCmd == 2'd0) begin
        chkEq("R11", "shOut while no snoop", {31'd0, shOut}, 32'd0);
        chkEq("R11", "supplyValidOut while no snoop", {31'd0, supplyValidOut}, 32'd0);
      end
      if (!busGnt) chkEq("R1", "busCmdOut without grant", {30'd0, busCmdOut}, 32'd0);
    end
  end

  task automatic cpuOp(bit we, logic [AW-1:0] a, logic [DW-1:0] wd,
                       bit pShared, bit pHas, logic [DW-1:0] pData, string req);
    int idx;
    logic [AW-SB-1:0] tg;
    logic [DW-1:0] expR;
    bit memPend, done;
    busExp_t e;
    idx = int'(a[SB-1:0]);
    tg  = a[AW-1:SB];
    if (!(mSt[idx] != 0 && mTag[idx] == tg)) begin
      if (mSt[idx] == 2 || mSt[idx] == 4) begin
        expQ.push_back('{2'd3, {mTag[idx], SB'(idx)}, mData[idx], 1'b1});
        memOv[int'({mTag[idx], SB'(idx)})] = mData[idx];
      end
      expQ.push_back('{2'd1, a, '0, 1'b0});
      mTag[idx]  = tg;
      mData[idx] = pHas ? pData : memRd(int'(a));
      mSt[idx]   = pShared ? 3 : 1;
    end
    if (we) begin
      if (mSt[idx] == 3 || mSt[idx] == 4) begin
        expQ.push_back('{2'd2, a, wd, 1'b1});
        mSt[idx] = pShared ? 4 : 2;
      end else begin
        mSt[idx] = 2;
      end
      mData[idx] = wd;
    end
    expR = mData[idx];

    @(negedge clk);
    cpuReq = 1; cpuWe = we; cpuAddr = a; cpuWdata = wd;
    memPend = 0; done = 0;
    while (!done) begin
      busGnt = 0; memAck = 0; shIn = 0; supplyValidIn = 0;
      if (memPend) begin
        memAck = 1; memData = memRd(int'(a)); memPend = 0;
      end else if (busReq) begin
        busGnt = 1; shIn = pShared; supplyValidIn = pHas; supplyDataIn = pData;
        #1;
        if (expQ.size() == 0) begin
          chkEq(req, "unexpected bus command", {30'd0, busCmdOut}, 32'd0);
        end else begin
          e = expQ.pop_front();
          chkEq(req, "bus command", {30'd0, busCmdOut}, {30'd0, e.cmd});
          chkEq(req, "bus address", {24'd0, busAddrOut}, {24'd0, e.addr});
          if (e.chkData) chkEq(req, "bus data", {16'd0, busDataOut}, {16'd0, e.data});
          if (e.cmd == 2'd1 && !pHas) memPend = 1;
        end
      end
      #1;
      if (cpuDone) begin
        done = 1;
        if (!we) chkEq(req, "load data", {16'd0, cpuRdata}, {16'd0, expR});
      end
      @(negedge clk);
    end
    cpuReq = 0; busGnt = 0; memAck = 0; shIn = 0; supplyValidIn = 0;
    chkEq(req, "bus commands left over", expQ.size(), 0);
    expQ.delete();
  endtask

  task automatic snoop(logic [1:0] cmd, logic [AW-1:0] a, logic [DW-1:0] d, string req);
    int idx;
    bit hit;
    idx = int'(a[SB-1:0]);
    hit = (mSt[idx] != 0) && (mTag[idx] == a[AW-1:SB]);
    @(negedge clk);
    snpCmd = cmd; snpAddr = a; snpData = d;
    #1;
    chkEq(req, "shOut", {31'd0, shOut}, {31'd0, hit && (cmd == 2'd1 || cmd == 2'd2)});
    chkEq(req, "supplyValidOut", {31'd0, supplyValidOut}, {31'd0, hit && cmd == 2'd1});
    if (hit && cmd == 2'd1) chkEq(req, "supplied word", {16'd0, supplyDataOut}, {16'd0, mData[idx]});
    if (hit && cmd == 2'd1) begin
      if (mSt[idx] == 1) mSt[idx] = 3;
      else if (mSt[idx] == 2) mSt[idx] = 4;
    end else if (hit && cmd == 2'd2) begin
      mData[idx] = d; mSt[idx] = 3;
    end
    @(negedge clk);
    snpCmd = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    for (int i = 0; i < NS; i++) begin mSt[i] = 0; mTag[i] = '0; mData[i] = '0; end
    rst_n = 0; cpuReq = 0; cpuWe = 0; cpuAddr = '0; cpuWdata = '0;
    busGnt = 0; shIn = 0; supplyValidIn = 0; supplyDataIn = '0;
    memAck = 0; memData = '0; snpCmd = 0; snpAddr = '0; snpData = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chkEq("R1", "busReq in reset", {31'd0, busReq}, 32'd0);
    chkEq("R1", "cpuDone in reset", {31'd0, cpuDone}, 32'd0);
    rst_n = 1;
    snoop(2'd1, 8'h04, '0, "R1");
    snoop(2'd2, 8'h13, 16'h1111, "R1");

    cpuOp(0, 8'h04, '0, 0, 0, '0, "R8");           // miss, memory fill, exclusive-clean
    cpuOp(0, 8'h04, '0, 0, 0, '0, "R13");          // load hit
    cpuOp(1, 8'h04, 16'hA001, 0, 0, '0, "R9");     // silent store
    snoop(2'd1, 8'h04, '0, "R10");                 // supply and downgrade to shared-modified
    cpuOp(1, 8'h04, 16'hA002, 1, 0, '0, "R2");     // update broadcast, sharing continues
    cpuOp(1, 8'h04, 16'hA003, 0, 0, '0, "R4");     // update, no sharer, becomes exclusive
    cpuOp(1, 8'h04, 16'hA004, 0, 0, '0, "R4");     // now silent
    cpuOp(0, 8'h08, '0, 1, 1, 16'h5EED, "R6");     // dirty victim write-back, peer supply
    cpuOp(0, 8'h08, '0, 0, 0, '0, "R7");
    cpuOp(1, 8'h08, 16'hB001, 1, 0, '0, "R5");     // update, no memory write
    snoop(2'd2, 8'h08, 16'hBEEF, "R3");            // peer update overwrites
    cpuOp(0, 8'h08, '0, 0, 0, '0, "R3");
    cpuOp(0, 8'h0C, '0, 0, 0, '0, "R6");           // clean victim dropped silently
    snoop(2'd3, 8'h0C, 16'h2222, "R11");
    snoop(2'd1, 8'h10, '0, "R11");
    cpuOp(0, 8'h0C, '0, 0, 0, '0, "R11");
    cpuOp(1, 8'h21, 16'hC001, 1, 1, 16'h7777, "R12"); // store miss, shared fill, update
    cpuOp(0, 8'h03, '0, 1, 0, '0, "R8");           // shared fill from memory
    cpuOp(1, 8'h03, 16'hD001, 1, 0, '0, "R8");
    cpuOp(0, 8'h25, '0, 0, 0, '0, "R5");           // shared-modified victim written back
    cpuOp(1, 8'h0E, 16'hE001, 0, 0, '0, "R12");    // store miss, exclusive fill, silent store
    snoop(2'd1, 8'h0E, '0, "R10");
    cpuOp(0, 8'h02, '0, 0, 0, '0, "R6");           // shared-modified victim from downgrade
    repeat (2) @(negedge clk);
    summary();
  end

endmodule